// File: doc/BRIEF.md
# Sixteen-Level Wakeup Interrupt Controller

This block gathers wakeup requests from devices on sixteen interrupt levels and hands them to an instruction sequencer at instruction boundaries. Each level has one pending bit. A device strobe sets its level's bit, and several strobes arriving before the next service collapse into a single request. When the sequencer raises its boundary strobe and delivery is allowed, the controller does three things in one edge: it takes a snapshot of the pending bits, clears them, and starts to drain the snapshot. Draining produces one notify pulse per requested level, from the highest level down to level 0.

Delivery is gated by a nesting counter. A disable command raises the counter and an enable command lowers it. Interrupts reach the sequencer only while the counter is zero. A command that would push the counter above its maximum, or below zero, is refused and reported on a trap output.

A fixed, read-only mask output tells software which levels are kept for internal sources such as a periodic timeout tick.

Top module: `wake_irq_ctrl`

## Requirements
- R1: A high `wake_i[i]` sets pending bit i at the next edge. Any number of strobes on level i before a service yields exactly one notify for level i in that service.
- R2: A `wake_i[i]` strobe in the same cycle as the boundary strobe that snapshots and clears the pending bits is not lost. Bit i stays pending after that edge.
- R3: `irq_pending_o` is high exactly when at least one pending bit is set and the nesting count is zero.
- R4: A service starts when `sample_i` is high, the count is zero and no drain is running. It issues one one-hot `notify_o` per snapshot bit, one per cycle, in the cycles right after the start edge, with bit i of `notify_o` standing for level i, in strictly falling level order.
- R5: `disable_i` alone raises `nest_o` by one and `enable_i` alone lowers it by one, at the next edge. Both together leave it unchanged.
- R6: `disable_i` alone when the count is at NEST_MAX, or `enable_i` alone when it is zero, leaves the count unchanged. It drives `trap_o` high for exactly the following cycle.
- R7: `reserved_mask_o` always equals the RESERVED_MASK parameter (default 16'h0001, level 0).
- R8: `svc_done_o` pulses for one cycle in the cycle after the last notify of a service. `svc_any_o` is then 1 if the service issued a notify and 0 if the snapshot was empty. An empty snapshot gives the done pulse in the second cycle after the start edge.
- R9: `sample_i` has no effect while the count is nonzero or a drain is running. No notify is issued and the pending bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 16 | Per-level wakeup strobes |
| sample_i | input | 1 | Instruction-boundary strobe |
| disable_i | input | 1 | Raise the nesting count |
| enable_i | input | 1 | Lower the nesting count |
| irq_pending_o | output | 1 | Deliverable interrupt present |
| notify_o | output | 16 | One-hot level being notified |
| svc_done_o | output | 1 | Service finished pulse |
| svc_any_o | output | 1 | Last service issued a notify |
| trap_o | output | 1 | Nesting misuse pulse |
| nest_o | output | 3 | Current nesting count |
| reserved_mask_o | output | 16 | Levels kept for internal use |

## Verification
A corrupted pending bit appears at the ports as a missing or extra notify in the next service. It also shows as a wrong `irq_pending_o` one cycle after the strobe. A drifting nesting count shows on `nest_o` and `irq_pending_o` in the cycle after the command. A count that slipped past a bound shows as a missing trap pulse. A snapshot register that mis-shifts is exposed during the drain itself, as an out-of-order or non-one-hot notify, or as a done pulse that comes a cycle early or late.

// File: rtl/wic_pkg.sv
package wic_pkg;

    typedef enum logic {
        SCAN_IDLE,
        SCAN_RUN
    } scan_state_e;

    typedef struct packed {
        logic up;
        logic down;
    } nest_cmd_t;

    typedef enum logic [1:0] {
        NEST_HOLD,
        NEST_INC,
        NEST_DEC,
        NEST_BAD
    } nest_op_e;

    function automatic nest_op_e decode_nest(nest_cmd_t cmd, logic at_max, logic at_zero);
        nest_op_e op;
        op = NEST_HOLD;
        if (cmd.up && !cmd.down)
            op = at_max ? NEST_BAD : NEST_INC;
        else if (cmd.down && !cmd.up)
            op = at_zero ? NEST_BAD : NEST_DEC;
        return op;
    endfunction

endpackage

// File: rtl/wic_pending.sv
module wic_pending #(
    parameter int LEVELS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] wake_i,
    input  logic              take_i,
    output logic [LEVELS-1:0] pend_o
);
    logic [LEVELS-1:0] pend_q;

    for (genvar g = 0; g < LEVELS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[g] <= 1'b0;
            else if (take_i)
                pend_q[g] <= wake_i[g];
            else
                pend_q[g] <= pend_q[g] | wake_i[g];
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/wic_nest.sv
module wic_nest
    import wic_pkg::*;
#(
    parameter int NEST_MAX = 7,
    parameter int NEST_W   = $clog2(NEST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  nest_cmd_t         cmd_i,
    output logic [NEST_W-1:0] count_o,
    output logic              zero_o,
    output logic              trap_o
);
    localparam logic [NEST_W-1:0] TOP = NEST_W'(NEST_MAX);

    logic [NEST_W-1:0] cnt_q;
    logic              trap_q;
    nest_op_e          op;

    always_comb op = decode_nest(cmd_i, cnt_q == TOP, cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            trap_q <= 1'b0;
        end else begin
            trap_q <= (op == NEST_BAD);
            case (op)
                NEST_INC: cnt_q <= cnt_q + 1'b1;
                NEST_DEC: cnt_q <= cnt_q - 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;
    assign zero_o  = (cnt_q == '0);
    assign trap_o  = trap_q;
endmodule

// File: rtl/wic_scan.sv
module wic_scan
    import wic_pkg::*;
#(
    parameter int LEVELS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEVELS-1:0] snap_i,
    output logic [LEVELS-1:0] notify_o,
    output logic              done_o,
    output logic              any_o,
    output logic              busy_o
);
    scan_state_e       state_q;
    logic [LEVELS-1:0] snap_q;
    logic [LEVELS-1:0] top;
    logic [LEVELS-1:0] rest;
    logic              done_q;
    logic              any_q;

    always_comb begin
        top = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (snap_q[i]) begin
                top    = '0;
                top[i] = 1'b1;
            end
        end
        rest = snap_q & ~top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SCAN_IDLE;
            snap_q  <= '0;
            done_q  <= 1'b0;
            any_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SCAN_IDLE: begin
                    if (start_i) begin
                        snap_q  <= snap_i;
                        any_q   <= 1'b0;
                        state_q <= SCAN_RUN;
                    end
                end
                default: begin
                    if (top != '0)
                        any_q <= 1'b1;
                    snap_q <= rest;
                    if (rest == '0) begin
                        state_q <= SCAN_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy_o   = (state_q == SCAN_RUN);
    assign notify_o = busy_o ? top : '0;
    assign done_o   = done_q;
    assign any_o    = any_q;
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wic_pkg::*;
#(
    parameter int          LEVELS        = 16,
    parameter int          NEST_MAX      = 7,
    parameter int          NEST_W        = $clog2(NEST_MAX + 1),
    parameter logic [15:0] RESERVED_MASK = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LEVELS-1:0] wake_i,
    input  logic              sample_i,
    input  logic              disable_i,
    input  logic              enable_i,
    output logic              irq_pending_o,
    output logic [LEVELS-1:0] notify_o,
    output logic              svc_done_o,
    output logic              svc_any_o,
    output logic              trap_o,
    output logic [NEST_W-1:0] nest_o,
    output logic [LEVELS-1:0] reserved_mask_o
);
    logic [LEVELS-1:0] pend;
    logic              nest_zero;
    logic              busy;
    logic              take;
    nest_cmd_t         cmd;

    assign cmd.up   = disable_i;
    assign cmd.down = enable_i;
    assign take     = sample_i && nest_zero && !busy;

    wic_pending #(.LEVELS(LEVELS)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .wake_i (wake_i),
        .take_i (take),
        .pend_o (pend)
    );

    wic_nest #(.NEST_MAX(NEST_MAX), .NEST_W(NEST_W)) u_nest (
        .clk     (clk),
        .rst     (rst),
        .cmd_i   (cmd),
        .count_o (nest_o),
        .zero_o  (nest_zero),
        .trap_o  (trap_o)
    );

    wic_scan #(.LEVELS(LEVELS)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .start_i  (take),
        .snap_i   (pend),
        .notify_o (notify_o),
        .done_o   (svc_done_o),
        .any_o    (svc_any_o),
        .busy_o   (busy)
    );

    assign irq_pending_o   = (pend != '0) && nest_zero;
    assign reserved_mask_o = LEVELS'(RESERVED_MASK);
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
    parameter int LEVELS   = 16,
    parameter int NEST_MAX = 7,
    parameter int NEST_W   = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              disable_i,
    input logic              enable_i,
    input logic              irq_pending_o,
    input logic [LEVELS-1:0] notify_o,
    input logic              svc_done_o,
    input logic              trap_o,
    input logic [NEST_W-1:0] nest_o
);
    localparam logic [NEST_W-1:0] TOP = NEST_W'(NEST_MAX);

    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (nest_o != '0) |-> !irq_pending_o);

    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(notify_o));

    p_order_r4: assert property (@(posedge clk) disable iff (rst)
        ((notify_o != '0) && ($past(notify_o) != '0)) |-> (notify_o < $past(notify_o)));

    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        nest_o <= TOP);

    p_over_r6: assert property (@(posedge clk) disable iff (rst)
        (disable_i && !enable_i && nest_o == TOP) |=> (trap_o && nest_o == TOP));

    p_under_r6: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !disable_i && nest_o == '0) |=> (trap_o && nest_o == '0));

    p_quiet_done_r8: assert property (@(posedge clk) disable iff (rst)
        svc_done_o |-> (notify_o == '0));
endmodule

bind wake_irq_ctrl wic_checker #(
    .LEVELS(LEVELS), .NEST_MAX(NEST_MAX), .NEST_W(NEST_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .disable_i     (disable_i),
    .enable_i      (enable_i),
    .irq_pending_o (irq_pending_o),
    .notify_o      (notify_o),
    .svc_done_o    (svc_done_o),
    .trap_o        (trap_o),
    .nest_o        (nest_o)
);

// File: tb/tb_wake_irq_ctrl.sv
`timescale 1ns/1ps
module tb_wake_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] wake_i;
    logic        sample_i, disable_i, enable_i;
    logic        irq_pending_o, svc_done_o, svc_any_o, trap_o;
    logic [15:0] notify_o, reserved_mask_o;
    logic [2:0]  nest_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wake_irq_ctrl dut (
        .clk(clk), .rst(rst), .wake_i(wake_i), .sample_i(sample_i),
        .disable_i(disable_i), .enable_i(enable_i),
        .irq_pending_o(irq_pending_o), .notify_o(notify_o),
        .svc_done_o(svc_done_o), .svc_any_o(svc_any_o), .trap_o(trap_o),
        .nest_o(nest_o), .reserved_mask_o(reserved_mask_o)
    );

    localparam int NV = 6;
    localparam logic [15:0] PATS [NV] = '{
        16'h8001, 16'h0000, 16'h00F0, 16'hFFFF, 16'h2400, 16'h0001
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] top_bit(logic [15:0] v);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) if (v[i]) begin r = '0; r[i] = 1'b1; end
        return r;
    endfunction

    // sample issued in the current cycle; checks notify order and done
    task automatic drain(string req, logic [15:0] exp);
        logic [15:0] rem = exp;
        sample_i = 1'b1;
        tick();
        sample_i = 1'b0;
        if (rem == '0) begin
            chk(req, notify_o, 16'h0);
            tick();
        end
        while (rem != '0) begin
            chk(req, notify_o, top_bit(rem));
            rem = rem & ~top_bit(rem);
            tick();
        end
        chk("R8 done", svc_done_o, 1'b1);
        chk("R8 any", svc_any_o, exp != '0);
        chk("R8 notify idle", notify_o, 16'h0);
        tick();
        chk("R8 done pulse", svc_done_o, 1'b0);
    endtask

    task automatic cmd(logic d, logic e);
        disable_i = d; enable_i = e;
        tick();
        disable_i = 1'b0; enable_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wake_i = '0; sample_i = 0; disable_i = 0; enable_i = 0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // reset state
        chk("reset irq", irq_pending_o, 1'b0);
        chk("reset notify", notify_o, 16'h0);
        chk("reset nest", nest_o, 3'd0);
        chk("reset trap", trap_o, 1'b0);
        chk("reset done", svc_done_o, 1'b0);
        chk("R7 mask", reserved_mask_o, 16'h0001);

        // vector table: R1, R3, R4, R8
        for (int v = 0; v < NV; v++) begin
            wake_i = PATS[v];
            tick();
            wake_i = '0;
            chk("R3 pending", irq_pending_o, PATS[v] != '0);
            drain("R4 order", PATS[v]);
            chk("R1 cleared", irq_pending_o, 1'b0);
        end

        // R1 collapse
        for (int k = 0; k < 3; k++) begin wake_i = 16'h0020; tick(); end
        wake_i = '0;
        drain("R1 collapse", 16'h0020);

        // R2 wake during clearing sample
        wake_i = 16'h0008; tick();
        wake_i = 16'h0008; sample_i = 1'b1; tick();
        wake_i = '0; sample_i = 1'b0;
        chk("R2 notify", notify_o, 16'h0008);
        tick();
        chk("R2 done", svc_done_o, 1'b1);
        chk("R2 kept", irq_pending_o, 1'b1);
        drain("R2 second", 16'h0008);

        // R5 / R3 / R9 nesting gate
        cmd(1, 0);
        chk("R5 inc", nest_o, 3'd1);
        wake_i = 16'h0004; tick(); wake_i = '0;
        chk("R3 gated", irq_pending_o, 1'b0);
        sample_i = 1'b1; tick(); sample_i = 1'b0;
        chk("R9 no notify", notify_o, 16'h0);
        tick();
        chk("R9 no done", svc_done_o, 1'b0);
        cmd(1, 1);
        chk("R5 both hold", nest_o, 3'd1);
        cmd(0, 1);
        chk("R5 dec", nest_o, 3'd0);
        chk("R9 kept pending", irq_pending_o, 1'b1);
        drain("R9 after gate", 16'h0004);

        // R6 overflow and underflow
        for (int k = 0; k < 7; k++) cmd(1, 0);
        chk("R5 at max", nest_o, 3'd7);
        chk("R6 no early trap", trap_o, 1'b0);
        cmd(1, 0);
        chk("R6 over trap", trap_o, 1'b1);
        chk("R6 over hold", nest_o, 3'd7);
        tick();
        chk("R6 trap pulse", trap_o, 1'b0);
        for (int k = 0; k < 7; k++) cmd(0, 1);
        chk("R5 back to zero", nest_o, 3'd0);
        cmd(0, 1);
        chk("R6 under trap", trap_o, 1'b1);
        chk("R6 under hold", nest_o, 3'd0);

        // R9 sample during drain, wake during drain kept
        wake_i = 16'hF000; tick(); wake_i = '0;
        sample_i = 1'b1; tick();
        chk("R9 first", notify_o, 16'h8000);
        wake_i = 16'h0002; tick(); wake_i = '0;
        chk("R9 second", notify_o, 16'h4000);
        tick();
        sample_i = 1'b0;
        chk("R9 third", notify_o, 16'h2000);
        tick();
        chk("R9 fourth", notify_o, 16'h1000);
        tick();
        chk("R9 done", svc_done_o, 1'b1);
        chk("R9 late wake pending", irq_pending_o, 1'b1);
        tick();
        chk("R9 no restart", notify_o, 16'h0);
        drain("R9 late wake", 16'h0002);
        chk("R7 mask end", reserved_mask_o, 16'h0001);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule